// File: doc/BRIEF.md
# Fully Associative Translation Cache with Not-Recently-Used Replacement

This block caches recent page-table translations for a 32-bit virtual address space with 4 KB pages. The upper 20 bits of an address form the virtual page number. The lower 12 bits are the in-page offset, and they pass through unchanged. All entries are compared against the page number of a lookup at the same time. One cycle after the lookup, the block reports one of three outcomes: a hit with the physical address, a miss, or a protection fault.

On a miss, an external agent walks the page table and writes the new mapping through the refill port. The block names the slot to be overwritten on `victim_idx`. It chooses that slot from per-entry valid bits and use bits. A periodic tick clears every use bit, so a set use bit means the entry was touched in the current period. Each entry also tracks a dirty bit for write-back handling. A flush input drops every mapping in one cycle.

The response register is a small state machine. It has four states:
- `RS_IDLE`: there was no lookup in the previous cycle.
- `RS_HIT`: the lookup found a matching entry and the access was allowed.
- `RS_MISS`: no valid entry matched.
- `RS_FAULT`: a matching entry forbade the access.

Every state moves on each clock. A lookup leads to the state for its outcome, and a cycle with no lookup leads to `RS_IDLE`. Reset enters `RS_IDLE`.

Top module: `tlb_nru_top`

## Requirements
- R1: A lookup whose page number matches a valid entry that allows the access gives `rsp_hit`=1 one cycle later. In that cycle, `rsp_paddr` is the entry's physical page number concatenated with the 12-bit offset of the lookup. Any entry can hold any page.
- R2: A lookup that matches no valid entry gives `rsp_miss`=1 one cycle later, with `rsp_paddr`=0. At most one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high in any cycle. All three are 0 in a cycle that follows no lookup.
- R3: Protection has 2 bits: bit 0 allows reads and bit 1 allows writes. A matching lookup that breaks this rule gives `rsp_fault`=1, `rsp_paddr`=0 and `rsp_dirty`=0, and it does not set the entry's dirty bit.
- R4: A permitted write hit sets the entry's dirty bit. On a hit, `rsp_dirty` shows the entry's dirty state after the access. A refill clears the dirty bit of the slot it writes.
- R5: Any lookup that matches a valid entry sets that entry's use bit, including a lookup that faults. A refill sets the use bit of the new entry.
- R6: `ref_clear` sets every use bit to 0 at the next edge. Two exceptions apply in that same cycle: an entry hit by a lookup and an entry written by a refill both end with their use bit set.
- R7: `victim_idx` follows this priority. First choice is the lowest-indexed invalid entry. Next is the lowest-indexed entry whose use bit is 0. If all entries are valid with use bits set, the choice is entry 0. A refill writes the slot shown on `victim_idx` in its cycle.
- R8: `flush` invalidates every entry at the next edge, so later lookups miss. A flush overrides a refill in the same cycle.
- R9: After reset, no entry is valid, all response outputs are 0, and `victim_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write (0 = read) |
| lk_vaddr | input | 32 | Virtual address to translate |
| rf_valid | input | 1 | Refill the victim slot this cycle |
| rf_vpn | input | 20 | Virtual page number of the refill |
| rf_ppn | input | 20 | Physical page number of the refill |
| rf_prot | input | 2 | Protection of the refill (bit 0 read, bit 1 write) |
| ref_clear | input | 1 | Periodic tick that clears all use bits |
| flush | input | 1 | Invalidate all entries |
| rsp_hit | output | 1 | Previous-cycle lookup hit |
| rsp_miss | output | 1 | Previous-cycle lookup missed |
| rsp_fault | output | 1 | Previous-cycle lookup violated protection |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| rsp_dirty | output | 1 | Dirty state of the hit entry after the access |
| victim_idx | output | $clog2(ENTRIES) | Slot the next refill will write |

## Verification
The bench builds the block with `ENTRIES`=4 and keeps the other parameters at their defaults. With four slots, a few refills fill the table, so the case where every use bit is set, the fallback to entry 0, and eviction of a live mapping can all be reached within a handful of cycles. The small table also makes it cheap to test, slot by slot, how a tick interacts with a hit or a refill in the same cycle, and how a flush overrides a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // Outcome of the lookup presented in the previous cycle
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_HIT   = 2'd1,
        RS_MISS  = 2'd2,
        RS_FAULT = 2'd3
    } resp_e;

    // Protection field bit positions
    localparam int PROT_RD = 0;
    localparam int PROT_WR = 1;
    localparam int PROT_W  = 2;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              key,
    output logic                          any_match,
    output logic [IDX_W-1:0]              match_idx
);
    logic [ENTRIES-1:0] match_vec;

    // one comparator per entry, all in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        match_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) match_idx = IDX_W'(i);
        end
    end

    assign any_match = |match_vec;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] used,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] free_idx, cold_idx;
    logic             have_free, have_cold;

    always_comb begin
        free_idx  = '0;
        cold_idx  = '0;
        have_free = 1'b0;
        have_cold = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx  = IDX_W'(i);
                have_free = 1'b1;
            end
            if (!used[i]) begin
                cold_idx  = IDX_W'(i);
                have_cold = 1'b1;
            end
        end
        if (have_free)      victim = free_idx;
        else if (have_cold) victim = cold_idx;
        else                victim = '0;
    end
endmodule

// File: rtl/tlb_nru_top.sv
module tlb_nru_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic [PROT_W-1:0] rf_prot,
    input  logic             ref_clear,
    input  logic             flush,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_dirty,
    output logic [IDX_W-1:0] victim_idx
);
    // entry storage
    logic [ENTRIES-1:0]             val_q, use_q, drt_q;
    logic [ENTRIES-1:0]             val_n, use_n, drt_n;
    logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
    logic [ENTRIES-1:0][PROT_W-1:0] prot_q;

    // response state
    resp_e           st_q, st_n;
    logic [PA_W-1:0] pa_q, pa_n;
    logic            dty_q, dty_n;

    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic             allowed;

    tlb_cam #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_cam (
        .valid     (val_q),
        .tags      (tag_q),
        .key       (lk_vaddr[VA_W-1:PAGE_BITS]),
        .any_match (hit_any),
        .match_idx (hit_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid  (val_q),
        .used   (use_q),
        .victim (victim_idx)
    );

    assign allowed = lk_write ? prot_q[hit_idx][PROT_WR] : prot_q[hit_idx][PROT_RD];

    // entry bookkeeping: tick, then lookup, then refill, then flush
    always_comb begin
        val_n = val_q;
        use_n = ref_clear ? '0 : use_q;
        drt_n = drt_q;
        if (lk_valid && hit_any) begin
            use_n[hit_idx] = 1'b1;
            if (lk_write && allowed) drt_n[hit_idx] = 1'b1;
        end
        if (rf_valid) begin
            val_n[victim_idx] = 1'b1;
            use_n[victim_idx] = 1'b1;
            drt_n[victim_idx] = 1'b0;
        end
        if (flush) val_n = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            use_q <= '0;
            drt_q <= '0;
        end else begin
            val_q <= val_n;
            use_q <= use_n;
            drt_q <= drt_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rf_valid) begin
            tag_q[victim_idx]  <= rf_vpn;
            ppn_q[victim_idx]  <= rf_ppn;
            prot_q[victim_idx] <= rf_prot;
        end
    end

    // next response state
    always_comb begin
        st_n  = RS_IDLE;
        pa_n  = '0;
        dty_n = 1'b0;
        if (lk_valid) begin
            if (!hit_any) begin
                st_n = RS_MISS;
            end else if (!allowed) begin
                st_n = RS_FAULT;
            end else begin
                st_n  = RS_HIT;
                pa_n  = {ppn_q[hit_idx], lk_vaddr[PAGE_BITS-1:0]};
                dty_n = drt_q[hit_idx] | lk_write;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RS_IDLE;
            pa_q  <= '0;
            dty_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            pa_q  <= pa_n;
            dty_q <= dty_n;
        end
    end

    // outputs from state
    always_comb begin
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_fault = 1'b0;
        unique case (st_q)
            RS_IDLE:  ;
            RS_HIT:   rsp_hit   = 1'b1;
            RS_MISS:  rsp_miss  = 1'b1;
            RS_FAULT: rsp_fault = 1'b1;
        endcase
        rsp_paddr = pa_q;
        rsp_dirty = dty_q;
    end
endmodule

// File: rtl/tlb_nru_chk.sv
module tlb_nru_chk #(
    parameter int PA_W      = 32,
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            flush,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_dirty
);
    // R2: outcomes are exclusive
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_fault}));

    // R2: every lookup is answered next cycle
    a_r2_lookup_answered: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_hit || rsp_miss || rsp_fault));

    // R2: no outcome without a lookup
    a_r2_quiet_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(rsp_hit || rsp_miss || rsp_fault));

    // R1: offset passes through
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0]));

    // R3: faults carry no address and no dirty report
    a_r3_fault_blank: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0 && !rsp_dirty));

    // R8: lookup right after a flush misses
    a_r8_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 lk_valid |=> rsp_miss);
endmodule

bind tlb_nru_top tlb_nru_chk #(.PA_W(PA_W), .VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .flush     (flush),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .rsp_dirty (rsp_dirty)
);

// File: tb/test_tlb_nru_top.sv
module test_tlb_nru_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n;
    logic lk_valid, lk_write, rf_valid, ref_clear, flush;
    logic [31:0] lk_vaddr;
    logic [19:0] rf_vpn, rf_ppn;
    logic [1:0]  rf_prot;
    logic rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
    logic [31:0] rsp_paddr;
    logic [IW-1:0] victim_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_nru_top #(.ENTRIES(N)) i_tlb_nru_top (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_prot(rf_prot),
        .ref_clear(ref_clear), .flush(flush),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty), .victim_idx(victim_idx)
    );

    // {write, vaddr, outcome(0 none,1 hit,2 miss,3 fault), dirty, paddr}
    localparam logic [67:0] VEC [10] = '{
        {1'b0, 32'h0001_0123, 2'd1, 1'b0, 32'h0A00_0123},
        {1'b1, 32'h0001_0456, 2'd1, 1'b1, 32'h0A00_0456},
        {1'b0, 32'h0001_0000, 2'd1, 1'b1, 32'h0A00_0000},
        {1'b0, 32'h0002_0FFF, 2'd1, 1'b0, 32'h0B00_0FFF},
        {1'b1, 32'h0002_0004, 2'd3, 1'b0, 32'h0000_0000},
        {1'b0, 32'h0003_0008, 2'd3, 1'b0, 32'h0000_0000},
        {1'b1, 32'h0003_0010, 2'd1, 1'b1, 32'h0C00_0010},
        {1'b0, 32'h0004_0000, 2'd2, 1'b0, 32'h0000_0000},
        {1'b0, 32'h0002_0000, 2'd1, 1'b0, 32'h0B00_0000},
        {1'b0, 32'h0003_0000, 2'd3, 1'b0, 32'h0000_0000}
    };

    function automatic logic [1:0] outcome();
        if (rsp_hit)   return 2'd1;
        if (rsp_miss)  return 2'd2;
        if (rsp_fault) return 2'd3;
        return 2'd0;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_write = 0; lk_vaddr = '0;
        rf_valid = 0; rf_vpn = '0; rf_ppn = '0; rf_prot = '0;
        ref_clear = 0; flush = 0;
    endtask

    task automatic refill(logic [19:0] vpn, logic [19:0] ppn, logic [1:0] prot);
        rf_valid = 1; rf_vpn = vpn; rf_ppn = ppn; rf_prot = prot;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic lookup(logic wr, logic [31:0] va);
        lk_valid = 1; lk_write = wr; lk_vaddr = va;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R9: reset state
        check("R9 outcome", outcome(), 0);
        check("R9 victim", victim_idx, 0);
        lookup(0, 32'h0001_0000);
        check("R9 empty lookup misses", outcome(), 2);
        @(negedge clk);
        check("R2 quiet after no lookup", outcome(), 0);

        refill(20'h00010, 20'h0A000, 2'b11);
        check("R7 next free slot", victim_idx, 1);
        refill(20'h00020, 20'h0B000, 2'b01);
        refill(20'h00030, 20'h0C000, 2'b10);

        // R1 R2 R3 R4 vectors
        for (int i = 0; i < 10; i++) begin
            lookup(VEC[i][67], VEC[i][66:35]);
            check("R1/R2/R3 outcome", outcome(), VEC[i][34:33]);
            check("R1/R3 paddr", rsp_paddr, VEC[i][31:0]);
            check("R4 dirty report", rsp_dirty, VEC[i][32]);
        end

        // R7: invalid slot first, then all used -> entry 0
        check("R7 invalid slot 3", victim_idx, 3);
        refill(20'h00050, 20'h0D000, 2'b11);
        check("R7 all used picks 0", victim_idx, 0);

        // R6: tick clears, hits re-mark (R5)
        ref_clear = 1; @(negedge clk); idle_inputs();
        check("R6 after tick", victim_idx, 0);
        lookup(0, 32'h0001_0000);
        check("R5 hit marks slot 0", victim_idx, 1);
        lookup(0, 32'h0002_0000);
        check("R5 hit marks slot 1", victim_idx, 2);

        // R6: refill together with tick keeps new entry's use bit
        ref_clear = 1;
        refill(20'h00060, 20'h0E000, 2'b11);
        check("R6 refill+tick victim", victim_idx, 0);
        lookup(0, 32'h0006_00AB);
        check("R7 refill used slot 2", rsp_paddr, 32'h0E00_00AB);
        lookup(0, 32'h0003_0000);
        check("R7 evicted entry misses", outcome(), 2);

        // R6: hit together with tick keeps its use bit
        ref_clear = 1;
        lookup(0, 32'h0001_0000);
        check("R6 hit+tick victim", victim_idx, 1);

        // R8: flush
        flush = 1; @(negedge clk); idle_inputs();
        check("R8 victim after flush", victim_idx, 0);
        lookup(0, 32'h0006_0000);
        check("R8 flushed misses", outcome(), 2);
        lookup(0, 32'h0005_0000);
        check("R8 flushed misses D", outcome(), 2);

        // R4: refill over a dirty slot clears dirty
        refill(20'h00010, 20'h0F000, 2'b11);
        lookup(0, 32'h0001_0ABC);
        check("R4 refill clears dirty", rsp_dirty, 0);
        check("R4 refill paddr", rsp_paddr, 32'h0F00_0ABC);

        // R8: flush beats refill
        flush = 1;
        refill(20'h00070, 20'h01000, 2'b11);
        lookup(0, 32'h0007_0000);
        check("R8 flush over refill", outcome(), 2);
        lookup(0, 32'h0001_0000);
        check("R8 older entry gone", outcome(), 2);

        finish_run();
    end
endmodule